// File: doc/BRIEF.md
# Result Store Readback Pointer

This block holds the conversion results of a multichannel sampling converter in a small result store and returns them over a shared three-state data bus. A conversion sequencer writes each finished result through a simple synchronous write port. A host reads results back with an active-low read strobe while chip select is low. Every completed read moves an internal pointer on to the next channel that the configuration marks as enabled, so that consecutive reads walk through the converted channels in ascending order. Locations that are not enabled are skipped, and the walk wraps back to the lowest enabled channel.

The pointer goes back to the lowest enabled channel when a multichannel conversion is triggered, which the block sees as the falling edge of a chip-selected write strobe. A configuration write that carries the single-channel flag loads the pointer directly. This gives random access to any location, including one that is not enabled. While the power-down input is high, reads neither drive the bus nor move the pointer. All strobes are sampled on the system clock. The pointer moves one clock after the end of a read, so the bus value stays constant for the whole low phase of the read strobe.

Top module: `rdbk_top`

## Requirements
- R1: A write-port write of data D to location A (0..7) stores D, and a later read with the pointer at A returns D; a later write to the same location replaces the value.
- R2: While a read is live (cs_n=0, rd_n=0, pd=0), the bus carries the location at the pointer and stays constant. One clock after the read ends, the pointer moves to the lowest enabled location above its current value.
- R3: After a multichannel rewind, the first read returns the lowest enabled location, where bit i of chan_mask enables location i.
- R4: A read that finds no enabled location above the pointer wraps to the lowest enabled location.
- R5: A falling edge of wr_n while cs_n=0 rewinds the pointer to the lowest enabled location when single_mode=0. It has no effect on the pointer when single_mode=1.
- R6: A cycle with ld_req=1 and ld_single=1 loads the pointer from ld_addr, whether or not that location is enabled, and this takes priority over every other pointer update. With ld_single=0 the request leaves the pointer unchanged.
- R7: The bus is released (high impedance) unless cs_n=0, rd_n=0 and pd=0. A read strobe given while cs_n=1 neither drives the bus nor moves the pointer.
- R8: While pd=1 a read strobe does not drive the bus and does not move the pointer.
- R9: With chan_mask all zero, the pointer stays at location 0 through rewinds and reads.
- R10: Synchronous reset clears every location to 0x00 and sets the pointer to location 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| res_we | input | 1 | Result write enable from the sequencer |
| res_addr | input | 3 | Result write location |
| res_data | input | 8 | Result write data |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write (conversion) strobe, active low |
| pd | input | 1 | Power-down: blocks reads |
| chan_mask | input | 8 | Enabled channels, bit i for location i |
| single_mode | input | 1 | Current conversion is single-channel |
| ld_req | input | 1 | One-cycle configuration write request |
| ld_single | input | 1 | Single-channel flag of that configuration write |
| ld_addr | input | 3 | Location to load into the pointer |
| d_bus | inout | 8 | Three-state data bus |

## Verification
A wrong pointer can only be seen through the data that a later read puts on the bus. Each result location therefore holds a distinct value, so a pointer that skips, repeats, wraps wrongly or misses a rewind or load shows up as a wrong byte on the very next live read. An advance at the wrong moment, such as during the low phase, during power-down or while chip select is high, shows up as a changed byte in a held read, or as a wrong byte on the read that follows. A bus driven when it should be released is caught on a pulled-up bus, which then reads something other than all ones.

// File: rtl/rdbk_pkg.sv
package rdbk_pkg;

    localparam int unsigned LOCS_DEF = 8;
    localparam int unsigned DW_DEF   = 8;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_LOAD   = 2'd1,
        ACT_REWIND = 2'd2,
        ACT_STEP   = 2'd3
    } ptr_act_e;

    typedef struct packed {
        logic rd_live;
        logic rd_done;
        logic wr_fall;
    } strobe_evt_t;

endpackage

// File: rtl/rdbk_strobe.sv
module rdbk_strobe
    import rdbk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_n,
    input  logic        rd_n,
    input  logic        wr_n,
    input  logic        pd,
    output strobe_evt_t evt
);

    logic rd_act_q;
    logic wr_act_q;
    logic rd_now;
    logic wr_now;

    assign rd_now = ~cs_n & ~rd_n & ~pd;
    assign wr_now = ~cs_n & ~wr_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_act_q <= 1'b0;
            wr_act_q <= 1'b0;
        end else begin
            rd_act_q <= rd_now;
            wr_act_q <= wr_now;
        end
    end

    always_comb begin
        evt.rd_live = rd_now;
        evt.rd_done = rd_act_q & ~rd_now & ~pd;
        evt.wr_fall = wr_now & ~wr_act_q;
    end

endmodule

// File: rtl/rdbk_ram.sv
module rdbk_ram #(
    parameter int unsigned NLOC = 8,
    parameter int unsigned DW   = 8,
    parameter int unsigned AW   = $clog2(NLOC)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [NLOC];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NLOC; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/rdbk_ptr.sv
module rdbk_ptr
    import rdbk_pkg::*;
#(
    parameter int unsigned NLOC = 8,
    parameter int unsigned AW   = $clog2(NLOC)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NLOC-1:0] mask,
    input  ptr_act_e        act,
    input  logic [AW-1:0]   ld_addr,
    output logic [AW-1:0]   ptr
);

    function automatic logic [AW-1:0] lowest_on(input logic [NLOC-1:0] m);
        logic [AW-1:0] r;
        r = '0;
        for (int i = NLOC - 1; i >= 0; i--) begin
            if (m[i]) r = AW'(i);
        end
        return r;
    endfunction

    function automatic logic [AW-1:0] next_on(input logic [NLOC-1:0] m,
                                              input logic [AW-1:0]   cur);
        logic [AW-1:0] r;
        logic          hit;
        r   = '0;
        hit = 1'b0;
        for (int i = NLOC - 1; i >= 0; i--) begin
            if (m[i] && (AW'(i) > cur)) begin
                r   = AW'(i);
                hit = 1'b1;
            end
        end
        if (!hit) r = lowest_on(m);
        return r;
    endfunction

    logic [AW-1:0] ptr_d;

    always_comb begin
        unique case (act)
            ACT_LOAD:   ptr_d = ld_addr;
            ACT_REWIND: ptr_d = lowest_on(mask);
            ACT_STEP:   ptr_d = next_on(mask, ptr);
            default:    ptr_d = ptr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ptr <= '0;
        else     ptr <= ptr_d;
    end

endmodule

// File: rtl/rdbk_top.sv
module rdbk_top
    import rdbk_pkg::*;
#(
    parameter int unsigned NLOC = LOCS_DEF,
    parameter int unsigned DW   = DW_DEF,
    parameter int unsigned AW   = $clog2(NLOC)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            res_we,
    input  logic [AW-1:0]   res_addr,
    input  logic [DW-1:0]   res_data,
    input  logic            cs_n,
    input  logic            rd_n,
    input  logic            wr_n,
    input  logic            pd,
    input  logic [NLOC-1:0] chan_mask,
    input  logic            single_mode,
    input  logic            ld_req,
    input  logic            ld_single,
    input  logic [AW-1:0]   ld_addr,
    inout  wire  [DW-1:0]   d_bus
);

    strobe_evt_t   evt;
    ptr_act_e      act;
    logic [AW-1:0] ptr_q;
    logic [DW-1:0] rd_word;

    rdbk_strobe u_strobe (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .rd_n (rd_n),
        .wr_n (wr_n),
        .pd   (pd),
        .evt  (evt)
    );

    always_comb begin
        if (ld_req && ld_single)               act = ACT_LOAD;
        else if (evt.wr_fall && !single_mode)  act = ACT_REWIND;
        else if (evt.rd_done)                  act = ACT_STEP;
        else                                   act = ACT_HOLD;
    end

    rdbk_ptr #(.NLOC(NLOC), .AW(AW)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .mask    (chan_mask),
        .act     (act),
        .ld_addr (ld_addr),
        .ptr     (ptr_q)
    );

    rdbk_ram #(.NLOC(NLOC), .DW(DW), .AW(AW)) u_ram (
        .clk   (clk),
        .rst   (rst),
        .we    (res_we),
        .waddr (res_addr),
        .wdata (res_data),
        .raddr (ptr_q),
        .rdata (rd_word)
    );

    assign d_bus = evt.rd_live ? rd_word : {DW{1'bz}};

endmodule

// File: rtl/rdbk_chk.sv
module rdbk_chk #(
    parameter int unsigned NLOC = 8,
    parameter int unsigned AW   = $clog2(NLOC)
) (
    input logic            clk,
    input logic            rst,
    input logic            cs_n,
    input logic            rd_n,
    input logic            wr_n,
    input logic            pd,
    input logic [NLOC-1:0] chan_mask,
    input logic            single_mode,
    input logic            ld_req,
    input logic            ld_single,
    input logic [AW-1:0]   ld_addr,
    input logic [AW-1:0]   ptr
);

    logic [AW-1:0] first_c;
    logic          live;
    logic          ld_go;

    always_comb begin
        first_c = '0;
        for (int i = NLOC - 1; i >= 0; i--) begin
            if (chan_mask[i]) first_c = AW'(i);
        end
    end

    assign live  = ~cs_n & ~rd_n & ~pd;
    assign ld_go = ld_req & ld_single;

    // R2: pointer frozen while a read stays live
    a_r2_stable_in_read: assert property (@(posedge clk) disable iff (rst)
        (live && $past(live) && !$past(ld_go) && $past(wr_n || cs_n)) |-> $stable(ptr));

    // R5: rewind on a multichannel write strobe
    a_r5_rewind: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !wr_n && $past(wr_n || cs_n) && !single_mode && !ld_go)
        |=> (ptr == $past(first_c)));

    // R6: load from the configuration write
    a_r6_load: assert property (@(posedge clk) disable iff (rst)
        ld_go |=> (ptr == $past(ld_addr)));

    // R8: no pointer movement in power-down
    a_r8_pd_hold: assert property (@(posedge clk) disable iff (rst)
        (pd && !ld_go && (wr_n || cs_n)) |=> $stable(ptr));

    // R9: empty mask keeps location 0
    a_r9_empty_zero: assert property (@(posedge clk) disable iff (rst)
        (chan_mask == '0 && ptr == '0 && !ld_go) |=> (ptr == '0));

endmodule

bind rdbk_top rdbk_chk #(.NLOC(NLOC), .AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_n        (cs_n),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .pd          (pd),
    .chan_mask   (chan_mask),
    .single_mode (single_mode),
    .ld_req      (ld_req),
    .ld_single   (ld_single),
    .ld_addr     (ld_addr),
    .ptr         (ptr_q)
);

// File: tb/tb_rdbk_top.sv
module tb_rdbk_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       res_we = 1'b0;
    logic [2:0] res_addr = '0;
    logic [7:0] res_data = '0;
    logic       cs_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       pd = 1'b0;
    logic [7:0] chan_mask = '0;
    logic       single_mode = 1'b0;
    logic       ld_req = 1'b0;
    logic       ld_single = 1'b0;
    logic [2:0] ld_addr = '0;
    wire  [7:0] d_bus;

    for (genvar g = 0; g < 8; g++) begin : g_pull
        pullup (d_bus[g]);
    end

    rdbk_top dut (
        .clk(clk), .rst(rst), .res_we(res_we), .res_addr(res_addr),
        .res_data(res_data), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .pd(pd),
        .chan_mask(chan_mask), .single_mode(single_mode), .ld_req(ld_req),
        .ld_single(ld_single), .ld_addr(ld_addr), .d_bus(d_bus)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic [7:0] val;
        string      req;
    } exp_t;

    exp_t       sb[$];
    int         n_chk = 0;
    int         n_err = 0;
    logic [7:0] mem_m [8];
    logic       live_prev = 1'b0;
    int         cyc = 0;

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // monitor: pops one expected item at the start of each live read
    always @(negedge clk) begin
        logic live;
        exp_t e;
        live = !cs_n && !rd_n && !pd;
        if (live && !live_prev) begin
            if (sb.size() == 0) begin
                n_chk++;
                n_err++;
                $display("FAIL R2: got %h expected nothing", d_bus);
            end else begin
                e = sb.pop_front();
                check(d_bus, e.val, e.req);
            end
        end
        live_prev <= live;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout expected finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic ram_wr(input logic [2:0] a, input logic [7:0] d);
        res_we = 1'b1; res_addr = a; res_data = d; mem_m[a] = d;
        step(1);
        res_we = 1'b0;
    endtask

    task automatic do_read(input int loc, input string req, input int hold);
        exp_t e;
        e.val = mem_m[loc];
        e.req = req;
        sb.push_back(e);
        cs_n = 1'b0; rd_n = 1'b0;
        step(hold);
        check(d_bus, mem_m[loc], req);
        rd_n = 1'b1; cs_n = 1'b1;
        step(2);
    endtask

    task automatic wr_strobe();
        cs_n = 1'b0; wr_n = 1'b0;
        step(2);
        wr_n = 1'b1; cs_n = 1'b1;
        step(1);
    endtask

    task automatic cfg_load(input logic [2:0] a, input logic single);
        ld_req = 1'b1; ld_addr = a; ld_single = single;
        step(1);
        ld_req = 1'b0; ld_single = 1'b0;
        step(1);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) mem_m[i] = 8'h00;
        step(3);
        rst = 1'b0;
        step(1);

        // R10 / R7: idle bus released, reset contents zero at location 0
        #5 check(d_bus, 8'hFF, "R7");
        step(1);
        do_read(0, "R10", 1);

        for (int i = 0; i < 8; i++) ram_wr(3'(i), 8'(8'h20 + i * 8'h13));
        ram_wr(3'd5, 8'h5A);  // R1 overwrite

        chan_mask = 8'b1010_0110;
        single_mode = 1'b0;
        wr_strobe();
        do_read(1, "R3", 1);
        do_read(2, "R2", 1);
        do_read(5, "R1", 1);
        do_read(7, "R2", 1);
        do_read(1, "R4", 1);
        do_read(2, "R2", 4);   // long low phase, stable data
        wr_strobe();
        do_read(1, "R5", 1);
        single_mode = 1'b1;
        wr_strobe();
        do_read(2, "R5", 1);   // no rewind in single mode
        cfg_load(3'd4, 1'b1);
        do_read(4, "R6", 1);
        do_read(5, "R2", 1);
        cfg_load(3'd0, 1'b0);  // ignored without flag
        do_read(7, "R6", 1);

        // R7: read strobe with chip select high
        rd_n = 1'b0;
        step(1);
        check(d_bus, 8'hFF, "R7");
        rd_n = 1'b1;
        step(2);
        do_read(1, "R7", 1);

        // R8: power-down read
        pd = 1'b1;
        cs_n = 1'b0; rd_n = 1'b0;
        step(2);
        check(d_bus, 8'hFF, "R8");
        rd_n = 1'b1; cs_n = 1'b1;
        step(2);
        pd = 1'b0;
        step(1);
        do_read(2, "R8", 1);

        // R9: empty mask
        chan_mask = 8'h00;
        single_mode = 1'b0;
        wr_strobe();
        do_read(0, "R9", 1);
        do_read(0, "R9", 1);

        step(2);
        n_chk++;
        if (sb.size() != 0) begin
            n_err++;
            $display("FAIL R2: got %0d pending expected 0", sb.size());
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule